// File: doc/BRIEF.md
# Wake Interrupt Register Bank

This block is the register side of a wake controller. Up to eight wake-pin channels deliver one-cycle event pulses from trigger detectors outside the block. Each pulse latches a pending bit. Software reads the pending bits, enables them, and acknowledges them by writing ones to a separate acknowledge register. A single routing register holds two sets of bits. One set forwards each wake channel to a shared interrupt and each peripheral line (real-time clock, infrared, watchdog and so on) to its own interrupt output. The other set lets any pending source raise a system wake request.

Software reaches the registers through a single-cycle synchronous port. Read data appears one cycle after the request. The bank also recognises the per-channel configuration window. For an access there it raises a hit flag and gives the channel index. Read data for the window comes back in through an input, so the configuration words live elsewhere.

Top module: `wake_irq_bank`

## Requirements
- R1: After reset every register (pending, enable, routing) reads zero, and `wake_irq`, `wake_req` and `perip_irq_out` are low.
- R2: An event pulse on `chan_event[n]` sets pending bit n. The pending bits are read at offset 0x310, with bit n belonging to channel n. Writes to 0x310 have no effect.
- R3: Writing to the acknowledge register at 0x318 clears each pending bit n whose write-data bit n is 1. Bits written 0 keep their value. Reads of 0x318 return zero.
- R4: If an event and an acknowledge hit the same pending bit in the same cycle, the bit is set afterwards.
- R5: The enable register at offset 0x314 holds one enable bit per channel at bit n. It reads back what was written.
- R6: `wake_irq` is high exactly when some channel n has pending bit n, enable bit n and routing bit 8+n all set.
- R7: The routing register is at offset 0x31C. `perip_irq_out[p]` equals `perip_irq_in[p]` when routing bit p is 1, and is 0 otherwise.
- R8: `wake_req` is high exactly when some channel n is pending with routing bit 24+n set, or some `perip_irq_in[p]` is high with routing bit 16+p set. The enable register has no part in it.
- R9: Bits for channels or peripherals that are not implemented read as zero, and writes to them are ignored. This applies to enable bits at and above `NUM_CHAN` and to the matching routing bits.
- R10: An access to address 0x330 + 8·n with n < `NUM_CHAN` raises `cfg_hit` in that cycle, with `cfg_chan` = n. A read there returns `cfg_rdata`. A write there changes no internal register. Any other address leaves `cfg_hit` low.
- R11: `reg_rdata` is updated on the clock edge that samples a read, and holds its value until the next read. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| cfg_rdata | input | 32 | Read data from the external configuration words |
| cfg_hit | output | 1 | Current access falls in the configuration window |
| cfg_chan | output | 3 | Channel index of the configuration access |
| chan_event | input | NUM_CHAN | Event pulses from the trigger detectors |
| perip_irq_in | input | NUM_PERIP | Peripheral interrupt lines |
| perip_irq_out | output | NUM_PERIP | Forwarded peripheral interrupts |
| wake_irq | output | 1 | Shared wake-channel interrupt |
| wake_req | output | 1 | System wake request |

## Verification
A pending bit that is lost or stuck shows up on `wake_irq` or `wake_req` in the same cycle it goes wrong, because both outputs are combinational in the stored state. It also shows up on the next status read one cycle later. A routing or enable bit that is corrupted, or that lands in an unimplemented position, appears at once on the interrupt outputs and on the first read-back after the write. The bench therefore steps through single-bit patterns of routing against pending state, so that each gate is seen both open and closed. It also drives an event and an acknowledge into the same bit in the same cycle.

// File: rtl/wkb_pkg.sv
package wkb_pkg;
   localparam int unsigned DATA_W      = 32;
   localparam int unsigned MAX_CHAN    = 8;
   localparam int unsigned MAX_PERIP   = 8;
   localparam int unsigned CHAN_IDX_W  = 3;
   localparam int unsigned FWD_LSB     = 8;
   localparam int unsigned WAKE_OFS    = 16;
   localparam int unsigned CFG_STRIDE  = 8;

   localparam logic [11:0] OFS_PEND    = 12'h310;
   localparam logic [11:0] OFS_ENA     = 12'h314;
   localparam logic [11:0] OFS_ACK     = 12'h318;
   localparam logic [11:0] OFS_ROUTE   = 12'h31C;
   localparam logic [11:0] OFS_CFG     = 12'h330;

   function automatic logic [DATA_W-1:0] chan_bits(input int unsigned n);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < MAX_CHAN; i++)
         if (i < n) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [DATA_W-1:0] route_bits(input int unsigned nc,
                                                    input int unsigned np);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < MAX_PERIP; i++)
         if (i < np) begin
            m[i]            = 1'b1;
            m[WAKE_OFS + i] = 1'b1;
         end
      for (int unsigned i = 0; i < MAX_CHAN; i++)
         if (i < nc) begin
            m[FWD_LSB + i]            = 1'b1;
            m[WAKE_OFS + FWD_LSB + i] = 1'b1;
         end
      return m;
   endfunction
endpackage

// File: rtl/wkb_pending.sv
module wkb_pending #(
   parameter int unsigned NUM_CHAN = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CHAN-1:0] evt,
   input  logic                ack_we,
   input  logic [NUM_CHAN-1:0] ack_bits,
   output logic [NUM_CHAN-1:0] pend
);
   for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (evt[g])
            bit_q <= 1'b1;
         else if (ack_we && ack_bits[g])
            bit_q <= 1'b0;
      end
      assign pend[g] = bit_q;

      // R4
      evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt[g] |=> pend[g]);
      // R3
      ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_we && ack_bits[g] && !evt[g]) |=> !pend[g]);
      // R2
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!evt[g] && !(ack_we && ack_bits[g])) |=> $stable(pend[g]));
   end
endmodule

// File: rtl/wkb_ctrl_regs.sv
module wkb_ctrl_regs
   import wkb_pkg::*;
#(
   parameter int unsigned NUM_CHAN  = 8,
   parameter int unsigned NUM_PERIP = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ena_we,
   input  logic                route_we,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_CHAN-1:0] ena,
   output logic [DATA_W-1:0]   route
);
   localparam logic [DATA_W-1:0] ROUTE_MASK = route_bits(NUM_CHAN, NUM_PERIP);

   logic [NUM_CHAN-1:0] ena_q;
   logic [DATA_W-1:0]   route_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q   <= '0;
         route_q <= '0;
      end else begin
         if (ena_we)   ena_q   <= wdata[NUM_CHAN-1:0];
         if (route_we) route_q <= wdata & ROUTE_MASK;
      end
   end

   assign ena   = ena_q;
   assign route = route_q;

   // R5
   ena_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ena_we |=> (ena == $past(wdata[NUM_CHAN-1:0])));
   // R9
   route_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !route_we |=> $stable(route));
endmodule

// File: rtl/wkb_combine.sv
module wkb_combine
   import wkb_pkg::*;
#(
   parameter int unsigned NUM_CHAN  = 8,
   parameter int unsigned NUM_PERIP = 3
) (
   input  logic [NUM_CHAN-1:0]  pend,
   input  logic [NUM_CHAN-1:0]  ena,
   input  logic [DATA_W-1:0]    route,
   input  logic [NUM_PERIP-1:0] perip_in,
   output logic [NUM_PERIP-1:0] perip_out,
   output logic                 wake_irq,
   output logic                 wake_req
);
   logic [NUM_CHAN-1:0]  chan_fwd;
   logic [NUM_CHAN-1:0]  chan_wake;
   logic [NUM_PERIP-1:0] perip_wake;

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      assign chan_fwd[c]  = pend[c] & ena[c] & route[FWD_LSB + c];
      assign chan_wake[c] = pend[c] & route[WAKE_OFS + FWD_LSB + c];
   end

   for (genvar p = 0; p < NUM_PERIP; p++) begin : g_perip
      assign perip_out[p]  = perip_in[p] & route[p];
      assign perip_wake[p] = perip_in[p] & route[WAKE_OFS + p];
   end

   assign wake_irq = |chan_fwd;
   assign wake_req = (|chan_wake) | (|perip_wake);
endmodule

// File: rtl/wkb_regif.sv
module wkb_regif
   import wkb_pkg::*;
#(
   parameter int unsigned NUM_CHAN = 8,
   parameter int unsigned ADDR_W   = 12,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_en,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [NUM_CHAN-1:0]   pend,
   input  logic [NUM_CHAN-1:0]   ena,
   input  logic [DATA_W-1:0]     route,
   input  logic [DATA_W-1:0]     cfg_rdata,
   output logic                  ena_we,
   output logic                  route_we,
   output logic                  ack_we,
   output logic                  cfg_hit,
   output logic [CHAN_IDX_W-1:0] cfg_chan,
   output logic [DATA_W-1:0]     reg_rdata
);
   localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_ENA   = ADDR_W'(OFS_ENA);
   localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);
   localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(OFS_ROUTE);
   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
   localparam int unsigned       STR_SH  = $clog2(CFG_STRIDE);

   logic [ADDR_W-1:0] cfg_off;
   logic              in_window;
   logic              wr_acc, rd_acc;
   logic [DATA_W-1:0] rd_next;

   assign wr_acc  = reg_en &  reg_wr;
   assign rd_acc  = reg_en & ~reg_wr;
   assign cfg_off = reg_addr - A_CFG;

   assign in_window = (reg_addr >= A_CFG)
                   && (cfg_off[STR_SH-1:0] == '0)
                   && ((cfg_off >> STR_SH) < ADDR_W'(NUM_CHAN));

   assign cfg_hit  = reg_en & in_window;
   assign cfg_chan = cfg_off[STR_SH +: CHAN_IDX_W];

   assign ena_we   = wr_acc && (reg_addr == A_ENA);
   assign route_we = wr_acc && (reg_addr == A_ROUTE);
   assign ack_we   = wr_acc && (reg_addr == A_ACK);

   always_comb begin
      rd_next = '0;
      if (in_window)
         rd_next = cfg_rdata;
      else if (reg_addr == A_PEND)
         rd_next[NUM_CHAN-1:0] = pend;
      else if (reg_addr == A_ENA)
         rd_next[NUM_CHAN-1:0] = ena;
      else if (reg_addr == A_ROUTE)
         rd_next = route;
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (rd_acc)
            rdata_q <= rd_next;
      end
      assign reg_rdata = rdata_q;

      // R3
      ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_acc && reg_addr == A_ACK) |=> (reg_rdata == '0));
      // R11
      rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_acc |=> $stable(reg_rdata));
   end else begin : g_rd_comb
      assign reg_rdata = rd_next;
   end

   // R10
   cfg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |-> !(ena_we || route_we || ack_we));
endmodule

// File: rtl/wake_irq_bank.sv
module wake_irq_bank
   import wkb_pkg::*;
#(
   parameter int unsigned NUM_CHAN  = 8,
   parameter int unsigned NUM_PERIP = 3,
   parameter int unsigned ADDR_W    = 12,
   parameter bit          RD_REG    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_en,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [DATA_W-1:0]     cfg_rdata,
   output logic                  cfg_hit,
   output logic [CHAN_IDX_W-1:0] cfg_chan,
   input  logic [NUM_CHAN-1:0]   chan_event,
   input  logic [NUM_PERIP-1:0]  perip_irq_in,
   output logic [NUM_PERIP-1:0]  perip_irq_out,
   output logic                  wake_irq,
   output logic                  wake_req
);
   if (NUM_CHAN < 1 || NUM_CHAN > MAX_CHAN) begin : g_bad_chan
      $error("NUM_CHAN must lie in 1..8");
   end
   if (NUM_PERIP < 1 || NUM_PERIP > MAX_PERIP) begin : g_bad_perip
      $error("NUM_PERIP must lie in 1..8");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("ADDR_W must be at least 10");
   end

   logic [NUM_CHAN-1:0] pend, ena;
   logic [DATA_W-1:0]   route;
   logic                ena_we, route_we, ack_we;

   wkb_regif #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W), .RD_REG(RD_REG)) u_regif (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .pend(pend), .ena(ena), .route(route),
      .cfg_rdata(cfg_rdata), .ena_we(ena_we), .route_we(route_we),
      .ack_we(ack_we), .cfg_hit(cfg_hit), .cfg_chan(cfg_chan),
      .reg_rdata(reg_rdata)
   );

   wkb_pending #(.NUM_CHAN(NUM_CHAN)) u_pending (
      .clk(clk), .rst_n(rst_n), .evt(chan_event), .ack_we(ack_we),
      .ack_bits(reg_wdata[NUM_CHAN-1:0]), .pend(pend)
   );

   wkb_ctrl_regs #(.NUM_CHAN(NUM_CHAN), .NUM_PERIP(NUM_PERIP)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ena_we(ena_we), .route_we(route_we),
      .wdata(reg_wdata), .ena(ena), .route(route)
   );

   wkb_combine #(.NUM_CHAN(NUM_CHAN), .NUM_PERIP(NUM_PERIP)) u_combine (
      .pend(pend), .ena(ena), .route(route), .perip_in(perip_irq_in),
      .perip_out(perip_irq_out), .wake_irq(wake_irq), .wake_req(wake_req)
   );

   // R6
   irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> (pend != '0) && (ena != '0));
   // R8
   wake_needs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (route[DATA_W-1:WAKE_OFS] != '0));
   // R7
   perip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route[NUM_PERIP-1:0] == '0) |-> (perip_irq_out == '0));
endmodule

// File: tb/test_wake_irq_bank.sv
module test_wake_irq_bank;
   import wkb_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;
   localparam int NP  = 3;

   typedef struct packed {
      logic        wr;
      logic [11:0] addr;
      logic [31:0] data;
      logic [3:0]  req;
   } vec_t;

   // write vectors carry data; read vectors carry the expected value
   localparam vec_t VEC [12] = '{
      '{1'b1, 12'h314, 32'hFFFF_FFFF, 4'd9},   // R9
      '{1'b0, 12'h314, 32'h0000_003F, 4'd9},
      '{1'b1, 12'h31C, 32'hFFFF_FFFF, 4'd9},
      '{1'b0, 12'h31C, 32'h3F07_3F07, 4'd9},
      '{1'b1, 12'h314, 32'h0000_0015, 4'd5},   // R5
      '{1'b0, 12'h314, 32'h0000_0015, 4'd5},
      '{1'b1, 12'h31C, 32'h0000_0500, 4'd7},   // R7
      '{1'b0, 12'h31C, 32'h0000_0500, 4'd7},
      '{1'b0, 12'h318, 32'h0000_0000, 4'd3},   // R3
      '{1'b0, 12'h320, 32'h0000_0000, 4'd11},  // R11
      '{1'b1, 12'h310, 32'h0000_00FF, 4'd2},   // R2
      '{1'b0, 12'h310, 32'h0000_0000, 4'd2}
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic            reg_en, reg_wr;
   logic [11:0]     reg_addr;
   logic [31:0]     reg_wdata, reg_rdata, cfg_rdata;
   logic            cfg_hit;
   logic [2:0]      cfg_chan;
   logic [NCH-1:0]  chan_event;
   logic [NP-1:0]   perip_irq_in, perip_irq_out;
   logic            wake_irq, wake_req;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wake_irq_bank #(.NUM_CHAN(NCH), .NUM_PERIP(NP)) i_wake_irq_bank (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit), .cfg_chan(cfg_chan),
      .chan_event(chan_event), .perip_irq_in(perip_irq_in),
      .perip_irq_out(perip_irq_out), .wake_irq(wake_irq), .wake_req(wake_req)
   );

   task automatic check(input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_en = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse_event(input logic [NCH-1:0] e);
      @(negedge clk);
      chan_event = e;
      @(negedge clk);
      chan_event = '0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      rst_n = 1'b0; reg_en = 1'b0; reg_wr = 1'b0; reg_addr = '0;
      reg_wdata = '0; cfg_rdata = '0; chan_event = '0; perip_irq_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      reg_read(12'h310, rd); check("R1 pending", rd, 32'h0);
      reg_read(12'h314, rd); check("R1 enable", rd, 32'h0);
      reg_read(12'h31C, rd); check("R1 route", rd, 32'h0);
      check("R1 outputs", {28'h0, wake_irq, wake_req, perip_irq_out[1:0]}, 32'h0);
      check("R1 perip2", {31'h0, perip_irq_out[2]}, 32'h0);

      // vector table
      for (int i = 0; i < 12; i++) begin
         if (VEC[i].wr)
            reg_write(VEC[i].addr, VEC[i].data);
         else begin
            reg_read(VEC[i].addr, rd);
            check($sformatf("R%0d table[%0d]", VEC[i].req, i), rd, VEC[i].data);
         end
      end

      // R2 / R6 events and forwarding
      reg_write(12'h314, 32'h3F);
      reg_write(12'h31C, 32'h3F00);
      pulse_event(6'h05);
      reg_read(12'h310, rd); check("R2 pending after events", rd, 32'h05);
      check("R6 irq forwarded", {31'h0, wake_irq}, 32'h1);
      reg_write(12'h31C, 32'h0);
      check("R6 irq blocked by route", {31'h0, wake_irq}, 32'h0);
      reg_write(12'h31C, 32'h3F00);
      reg_write(12'h314, 32'h3A);
      check("R6 irq blocked by enable", {31'h0, wake_irq}, 32'h0);

      // R8 wake request ignores enable
      reg_write(12'h31C, 32'h0100_0000);
      check("R8 wake from chan0", {31'h0, wake_req}, 32'h1);
      reg_write(12'h31C, 32'h0200_0000);
      check("R8 no wake chan1 idle", {31'h0, wake_req}, 32'h0);

      // R7 / R8 peripherals
      @(negedge clk); perip_irq_in = 3'b111;
      reg_write(12'h31C, 32'h0000_0002);
      check("R7 perip forward", {29'h0, perip_irq_out}, 32'h2);
      check("R8 no perip wake", {31'h0, wake_req}, 32'h0);
      reg_write(12'h31C, 32'h0004_0000);
      check("R8 perip wake", {31'h0, wake_req}, 32'h1);
      check("R7 perip blocked", {29'h0, perip_irq_out}, 32'h0);
      @(negedge clk); perip_irq_in = 3'b011;
      #1 check("R8 perip wake drops", {31'h0, wake_req}, 32'h0);

      // R3 acknowledge
      reg_write(12'h318, 32'h01);
      reg_read(12'h310, rd); check("R3 ack bit0", rd, 32'h04);
      reg_write(12'h318, 32'h00);
      reg_read(12'h310, rd); check("R3 ack zero no effect", rd, 32'h04);

      // R4 event beats acknowledge
      @(negedge clk);
      chan_event = 6'h04;
      reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 12'h318; reg_wdata = 32'h04;
      @(negedge clk);
      chan_event = '0; reg_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      reg_read(12'h310, rd); check("R4 event wins", rd, 32'h04);
      @(negedge clk);
      chan_event = 6'h02;
      reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 12'h318; reg_wdata = 32'h04;
      @(negedge clk);
      chan_event = '0; reg_en = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      reg_read(12'h310, rd); check("R4 different bits", rd, 32'h02);

      // R10 configuration window
      cfg_rdata = 32'hA5A5_0001;
      @(negedge clk);
      reg_en = 1'b1; reg_wr = 1'b0; reg_addr = 12'h358;
      #1 check("R10 hit ch5", {28'h0, cfg_hit, cfg_chan}, 32'hD);
      @(negedge clk); reg_en = 1'b0;
      check("R10 cfg read", reg_rdata, 32'hA5A5_0001);
      @(negedge clk);
      reg_en = 1'b1; reg_addr = 12'h360;
      #1 check("R10 no hit ch6", {31'h0, cfg_hit}, 32'h0);
      @(negedge clk); reg_en = 1'b0;
      check("R10 beyond window reads zero", reg_rdata, 32'h0);
      @(negedge clk);
      reg_en = 1'b1; reg_addr = 12'h334;
      #1 check("R10 misaligned no hit", {31'h0, cfg_hit}, 32'h0);
      @(negedge clk); reg_en = 1'b0;
      reg_write(12'h338, 32'hFF);
      reg_read(12'h314, rd); check("R10 cfg write leaves enable", rd, 32'h3A);

      // R11 read data holds
      repeat (2) @(negedge clk);
      check("R11 rdata holds", reg_rdata, 32'h3A);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule